// File: doc/BRIEF.md
# OTP Fuse Read Sequencer

This block reads a run of bytes out of a one-time-programmable fuse array for a host. The host places a start address, a byte count, a wanted bank and a burst preference on its inputs and pulses `go`. The block first makes sure the fuse array is switched to the wanted bank. It then powers the array up in a fixed order with a settle wait, and fetches the bytes one at a time through a request/ready handshake with the fuse macro. After the last byte, or after a timeout, it powers the array down in the reverse order and signals completion.

Each byte read starts with a one-cycle request that carries the address; the macro drops its ready flag on that request. The block then samples ready once every poll interval. On the first poll that sees ready it takes the low byte of the macro's status word and presents it to the host with a one-cycle valid strobe and a zero-based index. If ready is still low after the allowed number of polls, the block abandons the run and flags a busy error. The settle wait, the poll interval and the poll budget are all given in clock cycles.

States: `S_IDLE`, `S_BANK_CHK`, `S_BANK_WR`, `S_BANK_VFY`, `S_PU_MASK`, `S_PU_SW1`, `S_PU_SW2`, `S_PU_OPEN`, `S_RD_REQ`, `S_RD_POLL`, `S_PD_BURST`, `S_PD_ISO`, `S_PD_SW2`, `S_PD_SW1`, `S_PD_MASK`, `S_FINISH`. The transitions are:

- `S_IDLE` goes to `S_FINISH` on `go` with a zero count, and to `S_BANK_CHK` on `go` with a non-zero count.
- `S_BANK_CHK` goes to `S_PU_MASK` when the bank already matches, otherwise to `S_BANK_WR`. `S_BANK_WR` always goes to `S_BANK_VFY`.
- `S_BANK_VFY` goes to `S_PU_MASK` when the read-back matches, otherwise to `S_FINISH` with the error flag set.
- Power-up runs `S_PU_MASK` to `S_PU_SW1`. `S_PU_SW1` holds for the settle time, then goes to `S_PU_SW2`, then `S_PU_OPEN`, then `S_RD_REQ`.
- `S_RD_REQ` goes to `S_RD_POLL`. On a poll that sees ready, `S_RD_POLL` goes back to `S_RD_REQ` if bytes remain, otherwise to `S_PD_BURST`. On the last poll without ready it goes to `S_PD_BURST` with the error flag set.
- Power-down runs `S_PD_BURST` to `S_PD_ISO` to `S_PD_SW2`. `S_PD_SW2` holds for the settle time, then goes to `S_PD_SW1`, then `S_PD_MASK`, then `S_FINISH`.
- `S_FINISH` always goes to `S_IDLE`.

Top module: `otp_rd_seq`

## Requirements
- R1: While reset is held, and after it is released, `core_iso` is 1. `wr_mask_ovr`, `pwr_en_a`, `pwr_en_b`, `burst_en`, `fz_req`, `bank_wr`, `rd_valid` and `done` are all 0.
- R2: Power-up follows a fixed order. `wr_mask_ovr` rises first. `pwr_en_a` rises after it. `pwr_en_b` rises exactly SETTLE_CYC cycles after `pwr_en_a`. Only after that does `core_iso` fall to 0.
- R3: Power-down follows the reverse order. `core_iso` returns to 1 first. `pwr_en_b` falls after it. `pwr_en_a` falls exactly SETTLE_CYC cycles after `pwr_en_b`. `wr_mask_ovr` falls after that, and only then is `done` pulsed. This order also applies after a timeout.
- R4: For byte k (k counted from 0), the block issues one `fz_req` pulse with `fz_addr` = start address + k, modulo 2^ADDR_W. It then presents `rd_byte` equal to bits [7:0] of `fz_word` as sampled on the first poll that sees `fz_ready` = 1, together with `rd_index` = k and a one-cycle `rd_valid`. Bytes come out in increasing k. A request is issued only while `core_iso` = 0.
- R5: `fz_ready` is sampled once every POLL_GAP cycles. If MAX_POLLS consecutive samples are all 0, the run is abandoned: no byte is output for that address and no further requests are made. `core_iso` returns to 1 exactly MAX_POLLS*POLL_GAP+2 cycles after the cycle in which that request was high, and `done` comes with `err_busy` = 1.
- R6: A `go` with `byte_count` = 0 raises `done` in the cycle right after `go`, with `err_busy` = 0. It makes no fuse request and no bank write, and leaves the power outputs unchanged.
- R7: If `bank_cur` already equals `want_bank`, no bank write occurs. Otherwise there is exactly one `bank_wr` pulse carrying `want_bank` on `bank_wr_val`, followed by a read-back. If the read-back differs, `done` comes with `err_busy` = 1 and the array is never powered.
- R8: `burst_en` is 1 only while reads are in progress with `core_iso` = 0, and only for a run started with `burst_req` = 1. It drops to 0 before `core_iso` returns to 1.
- R9: `done` is high for exactly one cycle per run. `err_busy` keeps the result of the last run until the next `go`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe, taken in idle |
| start_addr | input | ADDR_W | First fuse address |
| byte_count | input | CNT_W | Number of bytes to read |
| want_bank | input | BANK_W | Bank to select before reading |
| burst_req | input | 1 | Request burst-read enable for this run |
| rd_valid | output | 1 | One-cycle strobe for a returned byte |
| rd_byte | output | 8 | Returned byte |
| rd_index | output | CNT_W | Zero-based position of the returned byte |
| done | output | 1 | One-cycle end-of-run pulse |
| err_busy | output | 1 | Last run ended on a timeout or a bank mismatch |
| wr_mask_ovr | output | 1 | Write-mask override for the power controller |
| pwr_en_a | output | 1 | First fuse power switch |
| pwr_en_b | output | 1 | Second fuse power switch |
| core_iso | output | 1 | Isolation between fuse and core, 1 = isolated |
| burst_en | output | 1 | Burst-read enable to the fuse macro |
| fz_req | output | 1 | One-cycle read request, clears macro ready |
| fz_addr | output | ADDR_W | Address of the current request |
| fz_ready | input | 1 | Macro ready flag |
| fz_word | input | WORD_W | Macro control/status word, data in bits [7:0] |
| bank_cur | input | BANK_W | Current bank read back from the macro |
| bank_wr | output | 1 | One-cycle bank write strobe |
| bank_wr_val | output | BANK_W | Bank value to write |

## Verification
The assertions assume three things about the environment. `go` only matters in idle. The macro may clear and set `fz_ready` at any time. `bank_cur` may change only after a `bank_wr` pulse. The power, isolation and request relations they check hold whatever the macro does. The bench's behavioural macro drops ready on each request and raises it a programmable number of cycles later, or never when a stall is wanted. Its bank register follows a write unless it is told to ignore writes. The bench drives `go` only after the previous `done`, so every run starts from idle.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;

    typedef enum logic [4:0] {
        S_IDLE,
        S_BANK_CHK,
        S_BANK_WR,
        S_BANK_VFY,
        S_PU_MASK,
        S_PU_SW1,
        S_PU_SW2,
        S_PU_OPEN,
        S_RD_REQ,
        S_RD_POLL,
        S_PD_BURST,
        S_PD_ISO,
        S_PD_SW2,
        S_PD_SW1,
        S_PD_MASK,
        S_FINISH
    } otp_state_t;

    typedef struct packed {
        logic wmask;
        logic sw_a;
        logic sw_b;
        logic iso;
        logic burst;
        logic req;
        logic bwr;
        logic fin;
    } otp_ctl_t;

endpackage

// File: rtl/otp_cycle_timer.sv
module otp_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] RELOAD = W'(LIMIT - 1);

    logic [W-1:0] cnt;
    logic         armed;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
        end else if (load) begin
            cnt   <= RELOAD;
            armed <= 1'b1;
        end else if (cnt != '0) begin
            cnt   <= cnt - 1'b1;
        end
    end

    assign expired = armed && (cnt == '0);
endmodule

// File: rtl/otp_poll_budget.sv
module otp_poll_budget #(
    parameter int MAX_POLLS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int W = $clog2(MAX_POLLS + 1);
    localparam logic [W-1:0] FINAL = W'(MAX_POLLS - 1);

    logic [W-1:0] used;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used <= '0;
        end else if (clr) begin
            used <= '0;
        end else if (inc && (used != FINAL)) begin
            used <= used + 1'b1;
        end
    end

    assign last = (used == FINAL);
endmodule

// File: rtl/otp_rd_seq.sv
module otp_rd_seq
    import otp_rd_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int CNT_W      = 11,
    parameter int WORD_W     = 32,
    parameter int BANK_W     = 1,
    parameter int SETTLE_CYC = 200000,
    parameter int POLL_GAP   = 200,
    parameter int MAX_POLLS  = 1000000,
    parameter bit HAS_BURST  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [BANK_W-1:0] want_bank,
    input  logic              burst_req,
    output logic              rd_valid,
    output logic [7:0]        rd_byte,
    output logic [CNT_W-1:0]  rd_index,
    output logic              done,
    output logic              err_busy,
    output logic              wr_mask_ovr,
    output logic              pwr_en_a,
    output logic              pwr_en_b,
    output logic              core_iso,
    output logic              burst_en,
    output logic              fz_req,
    output logic [ADDR_W-1:0] fz_addr,
    input  logic              fz_ready,
    input  logic [WORD_W-1:0] fz_word,
    input  logic [BANK_W-1:0] bank_cur,
    output logic              bank_wr,
    output logic [BANK_W-1:0] bank_wr_val
);
    localparam logic [CNT_W-1:0] ONE_LEFT = CNT_W'(1);

    otp_state_t state, nstate;
    otp_ctl_t   ctl;

    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  left;
    logic [CNT_W-1:0]  idx;
    logic [BANK_W-1:0] bank_lat;
    logic              burst_lat;
    logic              err_q;

    logic settle_load, settle_exp;
    logic poll_load, poll_tick;
    logic budget_clr, budget_inc, budget_last;
    logic bank_match;

    assign bank_match  = (bank_cur == bank_lat);
    assign settle_load = (state == S_PU_MASK) || (state == S_PD_ISO);
    assign poll_load   = (state == S_RD_REQ) || ((state == S_RD_POLL) && poll_tick);
    assign budget_clr  = (state == S_RD_REQ);
    assign budget_inc  = (state == S_RD_POLL) && poll_tick && !fz_ready;

    otp_cycle_timer #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (settle_load),
        .expired (settle_exp)
    );

    otp_cycle_timer #(.LIMIT(POLL_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (poll_load),
        .expired (poll_tick)
    );

    otp_poll_budget #(.MAX_POLLS(MAX_POLLS)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (budget_clr),
        .inc   (budget_inc),
        .last  (budget_last)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE: begin
                if (go) nstate = (byte_count == '0) ? S_FINISH : S_BANK_CHK;
            end
            S_BANK_CHK: nstate = bank_match ? S_PU_MASK : S_BANK_WR;
            S_BANK_WR:  nstate = S_BANK_VFY;
            S_BANK_VFY: nstate = bank_match ? S_PU_MASK : S_FINISH;
            S_PU_MASK:  nstate = S_PU_SW1;
            S_PU_SW1:   if (settle_exp) nstate = S_PU_SW2;
            S_PU_SW2:   nstate = S_PU_OPEN;
            S_PU_OPEN:  nstate = S_RD_REQ;
            S_RD_REQ:   nstate = S_RD_POLL;
            S_RD_POLL: begin
                if (poll_tick) begin
                    if (fz_ready)         nstate = (left == ONE_LEFT) ? S_PD_BURST : S_RD_REQ;
                    else if (budget_last) nstate = S_PD_BURST;
                end
            end
            S_PD_BURST: nstate = S_PD_ISO;
            S_PD_ISO:   nstate = S_PD_SW2;
            S_PD_SW2:   if (settle_exp) nstate = S_PD_SW1;
            S_PD_SW1:   nstate = S_PD_MASK;
            S_PD_MASK:  nstate = S_FINISH;
            S_FINISH:   nstate = S_IDLE;
            default:    nstate = S_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        ctl     = '0;
        ctl.iso = 1'b1;
        unique case (state)
            S_IDLE, S_BANK_CHK, S_BANK_VFY, S_PD_MASK: ;
            S_BANK_WR:  ctl.bwr = 1'b1;
            S_PU_MASK:  ctl.wmask = 1'b1;
            S_PU_SW1: begin
                ctl.wmask = 1'b1;
                ctl.sw_a  = 1'b1;
            end
            S_PU_SW2, S_PD_ISO: begin
                ctl.wmask = 1'b1;
                ctl.sw_a  = 1'b1;
                ctl.sw_b  = 1'b1;
            end
            S_PU_OPEN, S_PD_BURST: begin
                ctl.wmask = 1'b1;
                ctl.sw_a  = 1'b1;
                ctl.sw_b  = 1'b1;
                ctl.iso   = 1'b0;
            end
            S_RD_REQ, S_RD_POLL: begin
                ctl.wmask = 1'b1;
                ctl.sw_a  = 1'b1;
                ctl.sw_b  = 1'b1;
                ctl.iso   = 1'b0;
                ctl.burst = burst_lat;
                ctl.req   = (state == S_RD_REQ);
            end
            S_PD_SW2: begin
                ctl.wmask = 1'b1;
                ctl.sw_a  = 1'b1;
            end
            S_PD_SW1:   ctl.wmask = 1'b1;
            S_FINISH:   ctl.fin = 1'b1;
            default: ;
        endcase
    end

    assign wr_mask_ovr = ctl.wmask;
    assign pwr_en_a    = ctl.sw_a;
    assign pwr_en_b    = ctl.sw_b;
    assign core_iso    = ctl.iso;
    assign fz_req      = ctl.req;
    assign bank_wr     = ctl.bwr;
    assign done        = ctl.fin;
    assign fz_addr     = cur_addr;
    assign bank_wr_val = bank_lat;
    assign err_busy    = err_q;

    generate
        if (HAS_BURST) begin : g_burst
            assign burst_en = ctl.burst;
        end else begin : g_noburst
            assign burst_en = 1'b0;
        end
    endgenerate

    // run context and byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            left      <= '0;
            idx       <= '0;
            bank_lat  <= '0;
            burst_lat <= 1'b0;
            err_q     <= 1'b0;
            rd_valid  <= 1'b0;
            rd_byte   <= '0;
            rd_index  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if ((state == S_IDLE) && go) begin
                cur_addr  <= start_addr;
                left      <= byte_count;
                idx       <= '0;
                bank_lat  <= want_bank;
                burst_lat <= burst_req;
                err_q     <= 1'b0;
            end
            if ((state == S_BANK_VFY) && !bank_match) begin
                err_q <= 1'b1;
            end
            if ((state == S_RD_POLL) && poll_tick) begin
                if (fz_ready) begin
                    rd_valid <= 1'b1;
                    rd_byte  <= fz_word[7:0];
                    rd_index <= idx;
                    idx      <= idx + 1'b1;
                    cur_addr <= cur_addr + 1'b1;
                    left     <= left - 1'b1;
                end else if (budget_last) begin
                    err_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/otp_rd_seq_chk.sv
module otp_rd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_mask_ovr,
    input logic pwr_en_a,
    input logic pwr_en_b,
    input logic core_iso,
    input logic burst_en,
    input logic fz_req,
    input logic rd_valid,
    input logic done
);
    a_r2_b_needs_a: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en_b |-> pwr_en_a);

    a_r2_a_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_en_a |-> wr_mask_ovr);

    a_r2_open_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        !core_iso |-> (pwr_en_a && pwr_en_b));

    a_r3_b_drop_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en_b) |-> core_iso);

    a_r4_req_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        fz_req |-> !core_iso);

    a_r4_valid_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !core_iso);

    a_r8_burst_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        burst_en |-> !core_iso);

    a_r8_burst_off_before_iso: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_iso) |-> !$past(burst_en));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_done_after_powerdown: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!pwr_en_a && !wr_mask_ovr && core_iso));
endmodule

bind otp_rd_seq otp_rd_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_mask_ovr (wr_mask_ovr),
    .pwr_en_a    (pwr_en_a),
    .pwr_en_b    (pwr_en_b),
    .core_iso    (core_iso),
    .burst_en    (burst_en),
    .fz_req      (fz_req),
    .rd_valid    (rd_valid),
    .done        (done)
);

// File: tb/tb_otp_rd_seq.sv
`timescale 1ns/1ps
module tb_otp_rd_seq;
    localparam int AW = 8;
    localparam int CW = 8;
    localparam int SETTLE = 12;
    localparam int GAP = 3;
    localparam int MAXP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [CW-1:0] byte_count = '0;
    logic want_bank = 1'b0;
    logic burst_req = 1'b0;
    logic rd_valid, done, err_busy;
    logic [7:0] rd_byte;
    logic [CW-1:0] rd_index;
    logic wr_mask_ovr, pwr_en_a, pwr_en_b, core_iso, burst_en, fz_req;
    logic [AW-1:0] fz_addr;
    logic fz_ready;
    logic [31:0] fz_word;
    logic bank_cur;
    logic bank_wr, bank_wr_val;

    always #2.5 clk = ~clk;

    otp_rd_seq #(
        .ADDR_W(AW), .CNT_W(CW), .WORD_W(32), .BANK_W(1),
        .SETTLE_CYC(SETTLE), .POLL_GAP(GAP), .MAX_POLLS(MAXP), .HAS_BURST(1'b1)
    ) dut (
        .clk(clk), .rst_n(rst_n), .go(go), .start_addr(start_addr),
        .byte_count(byte_count), .want_bank(want_bank), .burst_req(burst_req),
        .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_index(rd_index),
        .done(done), .err_busy(err_busy), .wr_mask_ovr(wr_mask_ovr),
        .pwr_en_a(pwr_en_a), .pwr_en_b(pwr_en_b), .core_iso(core_iso),
        .burst_en(burst_en), .fz_req(fz_req), .fz_addr(fz_addr),
        .fz_ready(fz_ready), .fz_word(fz_word), .bank_cur(bank_cur),
        .bank_wr(bank_wr), .bank_wr_val(bank_wr_val)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    function automatic logic [7:0] fuse_val(input logic [AW-1:0] a);
        return 8'(a * 8'd29 + 8'd7);
    endfunction

    // behavioural fuse macro
    int mac_lat = 0;
    logic mac_stall = 1'b0;
    logic bank_deaf = 1'b0;
    logic pend;
    int lat_cnt;
    logic [AW-1:0] word_addr;

    assign fz_word = {24'hC0FFEE, fuse_val(word_addr)};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            fz_ready  <= 1'b1;
            pend      <= 1'b0;
            lat_cnt   <= 0;
            word_addr <= '0;
            bank_cur  <= 1'b0;
        end else begin
            if (bank_wr && !bank_deaf) bank_cur <= bank_wr_val;
            if (fz_req) begin
                fz_ready  <= 1'b0;
                pend      <= 1'b1;
                lat_cnt   <= mac_lat;
                word_addr <= fz_addr;
            end else if (pend && !mac_stall) begin
                if (lat_cnt == 0) begin
                    fz_ready <= 1'b1;
                    pend     <= 1'b0;
                end else begin
                    lat_cnt <= lat_cnt - 1;
                end
            end
        end
    end

    // monitor, sampled away from the active edge
    int t_mask_up, t_a_up, t_b_up, t_iso_dn, t_iso_up, t_b_dn, t_a_dn, t_mask_dn, t_done, t_req;
    int n_req, n_val, n_bwr, done_hi;
    logic burst_seen;
    logic [7:0] got_byte [0:15];
    logic [CW-1:0] got_idx [0:15];
    logic [AW-1:0] req_addr [0:15];
    logic pm_q, pa_q, pb_q, pi_q;

    task automatic clear_mon();
        t_mask_up = -1; t_a_up = -1; t_b_up = -1; t_iso_dn = -1; t_iso_up = -1;
        t_b_dn = -1; t_a_dn = -1; t_mask_dn = -1; t_done = -1; t_req = -1;
        n_req = 0; n_val = 0; n_bwr = 0; done_hi = 0; burst_seen = 1'b0;
    endtask

    always @(negedge clk) begin
        if (wr_mask_ovr && !pm_q) t_mask_up = cyc;
        if (!wr_mask_ovr && pm_q) t_mask_dn = cyc;
        if (pwr_en_a && !pa_q) t_a_up = cyc;
        if (!pwr_en_a && pa_q) t_a_dn = cyc;
        if (pwr_en_b && !pb_q) t_b_up = cyc;
        if (!pwr_en_b && pb_q) t_b_dn = cyc;
        if (!core_iso && pi_q) t_iso_dn = cyc;
        if (core_iso && !pi_q) t_iso_up = cyc;
        if (done) begin t_done = cyc; done_hi = done_hi + 1; end
        if (burst_en) burst_seen = 1'b1;
        if (bank_wr) n_bwr = n_bwr + 1;
        if (fz_req) begin
            if (n_req < 16) req_addr[n_req] = fz_addr;
            n_req = n_req + 1;
            t_req = cyc;
        end
        if (rd_valid) begin
            if (n_val < 16) begin
                got_byte[n_val] = rd_byte;
                got_idx[n_val]  = rd_index;
            end
            n_val = n_val + 1;
        end
        pm_q = wr_mask_ovr; pa_q = pwr_en_a; pb_q = pwr_en_b; pi_q = core_iso;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [AW-1:0] a, input logic [CW-1:0] n,
                          input logic bk, input logic br);
        clear_mon();
        @(negedge clk);
        start_addr = a; byte_count = n; want_bank = bk; burst_req = br; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int i = 0; i < 4000 && t_done < 0; i++) @(negedge clk);
        @(negedge clk);
        chk(t_done >= 0, "R9 run completes", t_done, 1);
        chk(done_hi == 1, "R9 done width", done_hi, 1);
    endtask

    task automatic t_reset();
        chk(core_iso == 1'b1, "R1 isolation", core_iso, 1);
        chk({wr_mask_ovr, pwr_en_a, pwr_en_b} == 3'b000, "R1 power off",
            {wr_mask_ovr, pwr_en_a, pwr_en_b}, 0);
        chk({burst_en, fz_req, bank_wr, rd_valid, done} == 5'b0, "R1 strobes idle",
            {burst_en, fz_req, bank_wr, rd_valid, done}, 0);
    endtask

    task automatic check_bytes(input logic [AW-1:0] a, input int n);
        chk(n_val == n, "R4 byte count", n_val, n);
        chk(n_req == n, "R4 request count", n_req, n);
        for (int k = 0; k < n && k < 16; k++) begin
            chk(got_byte[k] == fuse_val(AW'(a + k)), "R4 byte value", got_byte[k], fuse_val(AW'(a + k)));
            chk(got_idx[k] == CW'(k), "R4 byte index", got_idx[k], k);
            chk(req_addr[k] == AW'(a + k), "R4 request address", req_addr[k], AW'(a + k));
        end
    endtask

    task automatic check_power_order();
        chk(t_mask_up >= 0 && t_mask_up < t_a_up, "R2 mask before switch A", t_mask_up, t_a_up);
        chk(t_b_up - t_a_up == SETTLE, "R2 settle before switch B", t_b_up - t_a_up, SETTLE);
        chk(t_iso_dn > t_b_up, "R2 isolation release last", t_iso_dn, t_b_up + 1);
        chk(t_iso_up >= 0 && t_iso_up < t_b_dn, "R3 isolation first", t_iso_up, t_b_dn);
        chk(t_a_dn - t_b_dn == SETTLE, "R3 settle before switch A off", t_a_dn - t_b_dn, SETTLE);
        chk(t_mask_dn > t_a_dn, "R3 mask cleared after switch A", t_mask_dn, t_a_dn + 1);
        chk(t_done > t_mask_dn, "R3 done after mask clear", t_done, t_mask_dn + 1);
    endtask

    task automatic t_read_burst();
        mac_lat = 2;
        run_op(8'h10, 8'd4, 1'b0, 1'b1);
        check_bytes(8'h10, 4);
        check_power_order();
        chk(err_busy == 1'b0, "R9 no error", err_busy, 0);
        chk(n_bwr == 0, "R7 matching bank not written", n_bwr, 0);
        chk(burst_seen == 1'b1, "R8 burst on when asked", burst_seen, 1);
    endtask

    task automatic t_read_wrap();
        mac_lat = 0;
        run_op(8'hFE, 8'd3, 1'b0, 1'b0);
        check_bytes(8'hFE, 3);
        chk(burst_seen == 1'b0, "R8 burst off when not asked", burst_seen, 0);
    endtask

    task automatic t_zero();
        clear_mon();
        @(negedge clk);
        start_addr = 8'h40; byte_count = '0; want_bank = 1'b1; burst_req = 1'b1; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(done == 1'b1, "R6 done next cycle", done, 1);
        chk(err_busy == 1'b0, "R6 no error", err_busy, 0);
        repeat (3) @(negedge clk);
        chk(n_req == 0 && n_bwr == 0, "R6 no access", n_req + n_bwr, 0);
        chk(t_a_up < 0 && t_mask_up < 0, "R6 power untouched", t_a_up, -1);
    endtask

    task automatic t_timeout();
        mac_lat = 0;
        mac_stall = 1'b1;
        run_op(8'h20, 8'd3, 1'b0, 1'b1);
        mac_stall = 1'b0;
        chk(err_busy == 1'b1, "R5 busy error", err_busy, 1);
        chk(n_val == 0, "R5 no byte output", n_val, 0);
        chk(n_req == 1, "R5 no further request", n_req, 1);
        chk(t_iso_up - t_req == MAXP * GAP + 2, "R5 timeout length", t_iso_up - t_req, MAXP * GAP + 2);
        check_power_order();
        repeat (20) @(negedge clk);
        chk(err_busy == 1'b1, "R9 error held", err_busy, 1);
        run_op(8'h30, 8'd1, 1'b0, 1'b0);
        chk(err_busy == 1'b0, "R9 error cleared by next run", err_busy, 0);
        check_bytes(8'h30, 1);
    endtask

    task automatic t_bank_switch();
        mac_lat = 1;
        run_op(8'h05, 8'd2, 1'b1, 1'b0);
        chk(n_bwr == 1, "R7 one bank write", n_bwr, 1);
        chk(bank_cur == 1'b1, "R7 bank changed", bank_cur, 1);
        chk(err_busy == 1'b0, "R7 verified bank", err_busy, 0);
        check_bytes(8'h05, 2);
    endtask

    task automatic t_bank_fail();
        bank_deaf = 1'b1;
        run_op(8'h05, 8'd2, 1'b0, 1'b0);
        bank_deaf = 1'b0;
        chk(n_bwr == 1, "R7 write attempted", n_bwr, 1);
        chk(err_busy == 1'b1, "R7 read-back mismatch", err_busy, 1);
        chk(n_req == 0 && t_a_up < 0, "R7 no power on mismatch", n_req, 0);
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        pm_q = 1'b0; pa_q = 1'b0; pb_q = 1'b0; pi_q = 1'b1;
        clear_mon();
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_read_burst();
        t_read_wrap();
        t_zero();
        t_timeout();
        t_bank_switch();
        t_bank_fail();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule